// File: doc/BRIEF.md
# Non-Overlapping Phase Enable Sequencer

This block runs a scheduled datapath split into `N_PHASES` partitions, all driven by one system clock. Once a start pulse arrives it walks the global schedule steps 1 through T, one step per clock. For each step it raises exactly one phase enable: the enable of the partition that owns that step. Each partition's logic is therefore enabled once every `N_PHASES` cycles, while the datapath as a whole still finishes one step per cycle.

Alongside the enables, the block reports the current global step, the owning partition (numbered 1..`N_PHASES`) and the local step number inside that partition. A partition's registers can use the local step directly as their schedule index. Step t belongs to partition `t mod N`, except that multiples of N belong to partition N. Its local step is `ceil(t/N)`. After step T the block raises a one-cycle completion flag and returns to idle.

Top module: `phase_seq`

## Requirements
- R1: After reset and while idle, every phase enable, the step, partition and local-step outputs, and the done flag are all zero.
- R2: A start pulse seen while idle with a non-zero step count makes the step output read 1 in the following cycle. The step count is captured with that pulse.
- R3: While a run is in progress, exactly one phase enable is high. For partition k, the high bit is bit k-1 of `phase_en_o`.
- R4: Partitions follow one another in the order 1, 2, ..., N and then wrap, so each enable recurs every N cycles.
- R5: The partition output equals `t mod N`, or equals N when `t mod N` is zero.
- R6: The local-step output equals `ceil(t/N)`.
- R7: Every cycle of a run satisfies `t = (j-1)*N + k`, where j is the local step and k is the partition.
- R8: The cycle after step T shows `done_o` high for exactly one cycle. In that cycle all enables and counters are back to zero.
- R9: A start pulse or a change of the step count during a run has no effect. The run continues to its captured T.
- R10: A start pulse with a step count of zero is ignored, and the block stays idle.
- R11: A start pulse in the cycle where `done_o` is high begins a new run, whose step 1 follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; acted on only while idle |
| total_steps_i | input | STEP_W | Number of schedule steps T in a run |
| phase_en_o | output | N_PHASES | One-hot phase enables; bit k-1 selects partition k |
| step_o | output | STEP_W | Current global step t; 0 when idle |
| part_o | output | $clog2(N_PHASES+1) | Owning partition 1..N; 0 when idle |
| local_o | output | STEP_W | Local step inside the partition; 0 when idle |
| done_o | output | 1 | Single-cycle pulse after the last step |

## Verification
The completion pulse and the acceptance of a new start can occur in the same cycle. The block leaves its run state on the edge after step T, so a start pulse held during the `done_o` cycle must launch a fresh run. That run must come up at step 1, partition 1 and local step 1, without a stale local count carried over. The bench provokes this by raising start exactly in the sampled done cycle. It then checks that done drops and that the new run's mapping is correct from its first step to its last. In a separate test, a start pulse on the final step of a run, when the block is still busy, must be ignored.

// File: rtl/phseq_pkg.sv
package phseq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/phase_rotor.sv
module phase_rotor #(
  parameter int N      = 4,
  parameter int STEP_W = 12,
  localparam int PART_W = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              advance_i,
  output logic [PART_W-1:0] part_o,
  output logic [STEP_W-1:0] local_o,
  output logic [N-1:0]      phase_en_o
);
  logic [PART_W-1:0] part_q;
  logic [STEP_W-1:0] local_q;
  logic              wrap;

  // partition N (or idle 0) rolls over to 1 and opens a new local step
  assign wrap = (part_q == '0) || (part_q == PART_W'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q  <= '0;
      local_q <= '0;
    end else if (clear_i) begin
      part_q  <= '0;
      local_q <= '0;
    end else if (advance_i) begin
      if (wrap) begin
        part_q  <= PART_W'(1);
        local_q <= local_q + 1'b1;
      end else begin
        part_q  <= part_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_en
    assign phase_en_o[k] = (part_q == PART_W'(k + 1));
  end

  assign part_o  = part_q;
  assign local_o = local_q;

  assert_phases_disjoint_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_en_o));

  assert_last_phase_wraps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_en_o[N-1] && advance_i && !clear_i) |=> phase_en_o[0]);

  assert_first_phase_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_en_o[0] && advance_i && !clear_i) |=> phase_en_o[1]);
endmodule

// File: rtl/step_tracker.sv
module step_tracker
  import phseq_pkg::*;
#(
  parameter int STEP_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] total_i,
  output logic [STEP_W-1:0] step_o,
  output logic              run_o,
  output logic              done_o,
  output logic              advance_o,
  output logic              clear_o
);
  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] limit_q;
  logic              done_q;
  logic              running, last, launch;

  assign running = (state_q == ST_RUN);
  assign last    = running && (step_q == limit_q);
  assign launch  = !running && start_i && (total_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      limit_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        state_q <= ST_RUN;
        step_q  <= STEP_W'(1);
        limit_q <= total_i;
      end else if (last) begin
        state_q <= ST_IDLE;
        step_q  <= '0;
        done_q  <= 1'b1;
      end else if (running) begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign step_o    = step_q;
  assign run_o     = running;
  assign done_o    = done_q;
  assign advance_o = launch || (running && !last);
  assign clear_o   = last;

  assert_launch_at_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && start_i && total_i != '0) |=> (step_q == STEP_W'(1) && running));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!running && step_q == '0));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_limit_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !last) |=> (limit_q == $past(limit_q) && running));

  assert_zero_count_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && total_i == '0) |=> !running);
endmodule

// File: rtl/phase_seq.sv
module phase_seq #(
  parameter int N_PHASES = 4,
  parameter int STEP_W   = 12,
  localparam int PART_W  = $clog2(N_PHASES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [STEP_W-1:0]   total_steps_i,
  output logic [N_PHASES-1:0] phase_en_o,
  output logic [STEP_W-1:0]   step_o,
  output logic [PART_W-1:0]   part_o,
  output logic [STEP_W-1:0]   local_o,
  output logic                done_o
);
  logic run_w, adv_w, clr_w;

  step_tracker #(.STEP_W(STEP_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .total_i   (total_steps_i),
    .step_o    (step_o),
    .run_o     (run_w),
    .done_o    (done_o),
    .advance_o (adv_w),
    .clear_o   (clr_w)
  );

  phase_rotor #(.N(N_PHASES), .STEP_W(STEP_W)) u_rotor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clr_w),
    .advance_i  (adv_w),
    .part_o     (part_o),
    .local_o    (local_o),
    .phase_en_o (phase_en_o)
  );

  // global step rebuilt from the rotor's (partition, local) pair
  logic [31:0] recon_w;
  assign recon_w = (32'(local_o) - 32'd1) * 32'(N_PHASES) + 32'(part_o);

  assert_inverse_map_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> (recon_w == 32'(step_o)));

  assert_one_phase_in_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> ($countones(phase_en_o) == 1));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w |-> (phase_en_o == '0 && part_o == '0 && local_o == '0));
endmodule

// File: tb/phase_seq_test.sv
module phase_seq_test;
  localparam int N  = 4;
  localparam int SW = 12;
  localparam int PW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] total = '0;
  logic [N-1:0]  en;
  logic [SW-1:0] step, lstep;
  logic [PW-1:0] part;
  logic          done;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  phase_seq #(.N_PHASES(N), .STEP_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_steps_i(total),
    .phase_en_o(en), .step_o(step), .part_o(part), .local_o(lstep), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req, input int exp_done);
    chk({req, " enables"}, int'(en), 0);
    chk({req, " step"}, int'(step), 0);
    chk({req, " part"}, int'(part), 0);
    chk({req, " local"}, int'(lstep), 0);
    chk({req, " done"}, int'(done), exp_done);
  endtask

  // entered at the sample of step 1; returns at the done cycle
  task automatic run_body(input int t_last, input int poke_at);
    for (int t = 1; t <= t_last; t++) begin
      int k = (t % N == 0) ? N : t % N;
      int j = (t + N - 1) / N;
      chk("R2/R9 step", int'(step), t);
      chk("R3 one-hot enable", int'(en), 1 << (k - 1));
      chk("R5 partition", int'(part), k);
      chk("R6 local step", int'(lstep), j);
      chk("R7 inverse map", (int'(lstep) - 1) * N + int'(part), t);
      chk("R8 no early done", int'(done), 0);
      if (t == poke_at) begin
        start = 1'b1;
        total = SW'(2);
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk_idle("R8", 1);
  endtask

  task automatic launch(input int t_cnt);
    start = 1'b1;
    total = SW'(t_cnt);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk_idle("R1 reset", 0);
    @(negedge clk);
    chk_idle("R1 idle", 0);
  endtask

  task automatic t_plain(input int t_cnt);
    launch(t_cnt);
    run_body(t_cnt, 0);
    @(negedge clk);
    chk_idle("R8 after done", 0);
  endtask

  task automatic t_rotation;
    logic [N-1:0] prev;
    launch(3 * N);
    prev = en;
    for (int c = 1; c < 3 * N; c++) begin
      @(negedge clk);
      chk("R4 rotate", int'(en), (prev == N'(1 << (N - 1))) ? 1 : int'(prev) << 1);
      prev = en;
    end
    @(negedge clk);
    chk("R8 done after rotation", int'(done), 1);
    @(negedge clk);
  endtask

  task automatic t_ignore_restart;
    launch(9);
    run_body(9, 3);
    @(negedge clk);
    chk_idle("R9 no relaunch", 0);
  endtask

  task automatic t_start_on_last;
    launch(5);
    run_body(5, 5);
    @(negedge clk);
    chk_idle("R9 start on last step ignored", 0);
  endtask

  task automatic t_zero;
    launch(0);
    chk_idle("R10 zero count", 0);
    @(negedge clk);
    chk_idle("R10 still idle", 0);
  endtask

  task automatic t_back_to_back;
    launch(6);
    run_body(6, 0);
    start = 1'b1;
    total = SW'(5);
    @(negedge clk);
    start = 1'b0;
    chk("R11 done dropped", int'(done), 0);
    run_body(5, 0);
    @(negedge clk);
    chk_idle("R11 end", 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain(10);
    t_plain(1);
    t_plain(N);
    t_plain(2 * N + 3);
    t_rotation();
    t_ignore_restart();
    t_start_on_last();
    t_zero();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule